// File: doc/BRIEF.md
# Banked general register file

This block is the architectural register store of a 32-bit processor core. It holds sixteen integer registers, of which the low eight exist twice (an active copy and a shadow copy), and two complete banks of sixteen 32-bit floating-point registers. It also holds the status word and the floating-point control word, because those two words decide which copies are visible.

The integer bank in view is chosen by the logical AND of two status bits, a privileged-mode bit and a bank bit. When a status write changes that AND, the two copies of registers 0 to 7 trade places. Registers 8 to 15 are never duplicated. The floating-point banks trade places whenever a status write to the FP control word flips its bank-select bit. A selection change takes effect on the edge that writes the control word, so the next read already sees the other copies. A register write issued in that same cycle lands in the newly selected copy.

The status read value is not taken straight from storage. Four condition flags are held in their own flip-flops, where the execution logic can update them without a whole-word write. These flag values are merged into the stored word on every read.

Top module: `bank_regfile`

## Requirements
- R1: After reset the status word reads 0x700000F0, the FP control word reads 0x00040001, and every integer and floating-point register reads 0.
- R2: An integer register written at one clock edge returns the written value on the combinational read port from the next cycle on.
- R3: Integer registers 8 to 15 are shared and return the same value whichever integer bank is selected.
- R4: The integer bank select is status bit 30 AND status bit 29. When a status write changes it, registers 0 to 7 of the two banks trade places with no value lost, and the next cycle's reads see the new bank.
- R5: A status write that leaves (bit 30 AND bit 29) unchanged, such as setting only one of the two bits, does not change which values registers 0 to 7 return.
- R6: The FP bank select is FP control bit 21. Changing it in a control write makes all sixteen FP registers trade places with the other bank, with no value lost. A floating-point register written returns its value on the next cycle.
- R7: Status read bits 0, 1, 8 and 9 come from the held flags. The flag order on the flag inputs is {bit 9, bit 8, bit 1, bit 0}. A status write loads the flags from those bits of the written word. A flag write with no status write in the same cycle replaces only those four bits.
- R8: A register write issued in the same cycle as a control write that changes the bank select lands in the newly selected bank, for both the integer and the FP files.
- R9: A status or FP control write returns the written word on the corresponding read output from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gpr_we_i | input | 1 | Integer register write enable |
| gpr_waddr_i | input | 4 | Integer register write index |
| gpr_wdata_i | input | 32 | Integer register write data |
| gpr_raddr_i | input | 4 | Integer register read index |
| gpr_rdata_o | output | 32 | Integer register read data |
| fpr_we_i | input | 1 | FP register write enable |
| fpr_waddr_i | input | 4 | FP register write index |
| fpr_wdata_i | input | 32 | FP register write data |
| fpr_raddr_i | input | 4 | FP register read index |
| fpr_rdata_o | output | 32 | FP register read data |
| sr_we_i | input | 1 | Status word write enable |
| sr_wdata_i | input | 32 | Status word write data |
| flag_we_i | input | 1 | Held-flag write enable |
| flag_i | input | 4 | New flag values {bit 9, bit 8, bit 1, bit 0} |
| sr_o | output | 32 | Status word with flags merged |
| fpscr_we_i | input | 1 | FP control word write enable |
| fpscr_wdata_i | input | 32 | FP control word write data |
| fpscr_o | output | 32 | FP control word |

## Verification
Each integer bank is filled with a different marker pattern. The bench then moves the selection through every combination of the two status bits and reads registers 0 to 15 after each move. These reads tell a real exchange apart from lost data, from a swap driven by only one of the two bits, and from a swap that wrongly reaches the shared registers. The FP file gets the same treatment through the control-word bit. Writes issued together with a selection change show whether the write takes the old or the new bank. Flag patterns with both status writes and flag writes show whether the merge uses the right bit positions and which source wins.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned SR_MD_BIT = 30;
  localparam int unsigned SR_RB_BIT = 29;
  localparam int unsigned SR_T_BIT  = 0;
  localparam int unsigned SR_S_BIT  = 1;
  localparam int unsigned SR_Q_BIT  = 8;
  localparam int unsigned SR_M_BIT  = 9;
  localparam int unsigned FP_FR_BIT = 21;
  localparam logic [XLEN-1:0] SR_RST    = 32'h7000_00F0;
  localparam logic [XLEN-1:0] FPSCR_RST = 32'h0004_0001;

  typedef struct packed {
    logic m;
    logic q;
    logic s;
    logic t;
  } flags_t;
endpackage

// File: rtl/ctrl_words.sv
module ctrl_words
  import bank_rf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sr_we_i,
  input  logic [XLEN-1:0] sr_wdata_i,
  input  logic            flag_we_i,
  input  flags_t          flag_i,
  input  logic            fpscr_we_i,
  input  logic [XLEN-1:0] fpscr_wdata_i,
  output logic [XLEN-1:0] sr_o,
  output logic [XLEN-1:0] fpscr_o,
  output logic            gsel_rd_o,
  output logic            gsel_wr_o,
  output logic            fsel_rd_o,
  output logic            fsel_wr_o
);
  logic [XLEN-1:0] sr_q, fpscr_q, sr_nx, fpscr_nx;
  flags_t flg_q;

  assign sr_nx    = sr_we_i ? sr_wdata_i : sr_q;
  assign fpscr_nx = fpscr_we_i ? fpscr_wdata_i : fpscr_q;

  assign gsel_rd_o = sr_q[SR_MD_BIT] & sr_q[SR_RB_BIT];
  assign gsel_wr_o = sr_nx[SR_MD_BIT] & sr_nx[SR_RB_BIT];
  assign fsel_rd_o = fpscr_q[FP_FR_BIT];
  assign fsel_wr_o = fpscr_nx[FP_FR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= SR_RST;
      fpscr_q <= FPSCR_RST;
      flg_q   <= '{m: SR_RST[SR_M_BIT], q: SR_RST[SR_Q_BIT],
                   s: SR_RST[SR_S_BIT], t: SR_RST[SR_T_BIT]};
    end else begin
      sr_q    <= sr_nx;
      fpscr_q <= fpscr_nx;
      // full word write has priority over the flag port
      if (sr_we_i)
        flg_q <= '{m: sr_wdata_i[SR_M_BIT], q: sr_wdata_i[SR_Q_BIT],
                   s: sr_wdata_i[SR_S_BIT], t: sr_wdata_i[SR_T_BIT]};
      else if (flag_we_i)
        flg_q <= flag_i;
    end
  end

  always_comb begin
    sr_o           = sr_q;
    sr_o[SR_T_BIT] = flg_q.t;
    sr_o[SR_S_BIT] = flg_q.s;
    sr_o[SR_Q_BIT] = flg_q.q;
    sr_o[SR_M_BIT] = flg_q.m;
  end

  assign fpscr_o = fpscr_q;
endmodule

// File: rtl/gpr_banked.sv
module gpr_banked #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned NUM_REGS   = 16,
  parameter int unsigned NUM_BANKED = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sel_rd_i,
  input  logic                        sel_wr_i,
  input  logic                        we_i,
  input  logic [$clog2(NUM_REGS)-1:0] waddr_i,
  input  logic [XLEN-1:0]             wdata_i,
  input  logic [$clog2(NUM_REGS)-1:0] raddr_i,
  output logic [XLEN-1:0]             rdata_o
);
  localparam int unsigned AW         = $clog2(NUM_REGS);
  localparam int unsigned NUM_SHARED = NUM_REGS - NUM_BANKED;
  localparam int unsigned BW         = (NUM_BANKED > 1) ? $clog2(NUM_BANKED) : 1;
  localparam int unsigned SW         = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1;

  logic [XLEN-1:0] bank_q   [2][NUM_BANKED];
  logic [XLEN-1:0] shared_q [NUM_SHARED];
  logic [AW-1:0]   woff, roff;
  logic            w_low, r_low;

  assign w_low = waddr_i < AW'(NUM_BANKED);
  assign r_low = raddr_i < AW'(NUM_BANKED);
  assign woff  = waddr_i - AW'(NUM_BANKED);
  assign roff  = raddr_i - AW'(NUM_BANKED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NUM_BANKED; i++) bank_q[b][i] <= '0;
      for (int i = 0; i < NUM_SHARED; i++) shared_q[i] <= '0;
    end else if (we_i) begin
      if (w_low) bank_q[sel_wr_i][waddr_i[BW-1:0]] <= wdata_i;
      else       shared_q[woff[SW-1:0]]            <= wdata_i;
    end
  end

  assign rdata_o = r_low ? bank_q[sel_rd_i][raddr_i[BW-1:0]] : shared_q[roff[SW-1:0]];
endmodule

// File: rtl/fpr_banked.sv
module fpr_banked #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned NUM_REGS = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sel_rd_i,
  input  logic                        sel_wr_i,
  input  logic                        we_i,
  input  logic [$clog2(NUM_REGS)-1:0] waddr_i,
  input  logic [XLEN-1:0]             wdata_i,
  input  logic [$clog2(NUM_REGS)-1:0] raddr_i,
  output logic [XLEN-1:0]             rdata_o
);
  logic [XLEN-1:0] bank_q [2][NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NUM_REGS; i++) bank_q[b][i] <= '0;
    end else if (we_i) begin
      bank_q[sel_wr_i][waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = bank_q[sel_rd_i][raddr_i];
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_rf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        gpr_we_i,
  input  logic [3:0]  gpr_waddr_i,
  input  logic [31:0] gpr_wdata_i,
  input  logic [3:0]  gpr_raddr_i,
  output logic [31:0] gpr_rdata_o,
  input  logic        fpr_we_i,
  input  logic [3:0]  fpr_waddr_i,
  input  logic [31:0] fpr_wdata_i,
  input  logic [3:0]  fpr_raddr_i,
  output logic [31:0] fpr_rdata_o,
  input  logic        sr_we_i,
  input  logic [31:0] sr_wdata_i,
  input  logic        flag_we_i,
  input  logic [3:0]  flag_i,
  output logic [31:0] sr_o,
  input  logic        fpscr_we_i,
  input  logic [31:0] fpscr_wdata_i,
  output logic [31:0] fpscr_o
);
  logic gsel_rd, gsel_wr, fsel_rd, fsel_wr;

  ctrl_words u_ctrl (
    .clk_i, .rst_ni,
    .sr_we_i, .sr_wdata_i,
    .flag_we_i, .flag_i(flags_t'(flag_i)),
    .fpscr_we_i, .fpscr_wdata_i,
    .sr_o, .fpscr_o,
    .gsel_rd_o(gsel_rd), .gsel_wr_o(gsel_wr),
    .fsel_rd_o(fsel_rd), .fsel_wr_o(fsel_wr)
  );

  gpr_banked #(.XLEN(XLEN), .NUM_REGS(16), .NUM_BANKED(8)) u_gpr (
    .clk_i, .rst_ni,
    .sel_rd_i(gsel_rd), .sel_wr_i(gsel_wr),
    .we_i(gpr_we_i), .waddr_i(gpr_waddr_i), .wdata_i(gpr_wdata_i),
    .raddr_i(gpr_raddr_i), .rdata_o(gpr_rdata_o)
  );

  fpr_banked #(.XLEN(XLEN), .NUM_REGS(16)) u_fpr (
    .clk_i, .rst_ni,
    .sel_rd_i(fsel_rd), .sel_wr_i(fsel_wr),
    .we_i(fpr_we_i), .waddr_i(fpr_waddr_i), .wdata_i(fpr_wdata_i),
    .raddr_i(fpr_raddr_i), .rdata_o(fpr_rdata_o)
  );
endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        gpr_we_i,
  input logic [3:0]  gpr_waddr_i,
  input logic [31:0] gpr_wdata_i,
  input logic [3:0]  gpr_raddr_i,
  input logic [31:0] gpr_rdata_o,
  input logic        fpr_we_i,
  input logic [3:0]  fpr_waddr_i,
  input logic [31:0] fpr_wdata_i,
  input logic [3:0]  fpr_raddr_i,
  input logic [31:0] fpr_rdata_o,
  input logic        sr_we_i,
  input logic [31:0] sr_wdata_i,
  input logic        flag_we_i,
  input logic [3:0]  flag_i,
  input logic [31:0] sr_o,
  input logic        fpscr_we_i,
  input logic [31:0] fpscr_wdata_i,
  input logic [31:0] fpscr_o
);
  AST_SR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_we_i |=> sr_o == $past(sr_wdata_i)); // R9

  AST_FPSCR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpscr_we_i |=> fpscr_o == $past(fpscr_wdata_i)); // R9

  AST_SR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_we_i && !flag_we_i) |=> $stable(sr_o)); // R7

  AST_GPR_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_we_i |=> (gpr_raddr_i != $past(gpr_waddr_i) ||
                  gpr_rdata_o == $past(gpr_wdata_i))); // R8

  AST_FPR_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpr_we_i |=> (fpr_raddr_i != $past(fpr_waddr_i) ||
                  fpr_rdata_o == $past(fpr_wdata_i))); // R6

  AST_SHARED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_we_i && !gpr_we_i && gpr_raddr_i[3]) |=>
      (gpr_raddr_i != $past(gpr_raddr_i) || gpr_rdata_o == $past(gpr_rdata_o))); // R3

  AST_FPR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fpscr_we_i && !fpr_we_i) |=>
      (fpr_raddr_i != $past(fpr_raddr_i) || $stable(fpr_rdata_o))); // R6
endmodule

bind bank_regfile bank_regfile_chk u_chk (.*);

// File: tb/sim_bank_regfile.sv
`timescale 1ns/1ps
module sim_bank_regfile;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        gpr_we = 0, fpr_we = 0, sr_we = 0, flag_we = 0, fpscr_we = 0;
  logic [3:0]  gpr_wa = 0, gpr_ra = 0, fpr_wa = 0, fpr_ra = 0, flg = 0;
  logic [31:0] gpr_wd = 0, fpr_wd = 0, sr_wd = 0, fpscr_wd = 0;
  logic [31:0] gpr_rd, fpr_rd, sr_rd, fpscr_rd;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bank_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .gpr_we_i(gpr_we), .gpr_waddr_i(gpr_wa), .gpr_wdata_i(gpr_wd),
    .gpr_raddr_i(gpr_ra), .gpr_rdata_o(gpr_rd),
    .fpr_we_i(fpr_we), .fpr_waddr_i(fpr_wa), .fpr_wdata_i(fpr_wd),
    .fpr_raddr_i(fpr_ra), .fpr_rdata_o(fpr_rd),
    .sr_we_i(sr_we), .sr_wdata_i(sr_wd), .flag_we_i(flag_we), .flag_i(flg),
    .sr_o(sr_rd), .fpscr_we_i(fpscr_we), .fpscr_wdata_i(fpscr_wd), .fpscr_o(fpscr_rd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic gw(input int a, input logic [31:0] d);
    @(negedge clk); gpr_we = 1; gpr_wa = 4'(a); gpr_wd = d;
    @(negedge clk); gpr_we = 0;
  endtask
  task automatic fw(input int a, input logic [31:0] d);
    @(negedge clk); fpr_we = 1; fpr_wa = 4'(a); fpr_wd = d;
    @(negedge clk); fpr_we = 0;
  endtask
  task automatic srw(input logic [31:0] d);
    @(negedge clk); sr_we = 1; sr_wd = d;
    @(negedge clk); sr_we = 0;
  endtask
  task automatic fcw(input logic [31:0] d);
    @(negedge clk); fpscr_we = 1; fpscr_wd = d;
    @(negedge clk); fpscr_we = 0;
  endtask
  task automatic gchk(input string req, input int a, input logic [31:0] e);
    gpr_ra = 4'(a); #1; chk(req, gpr_rd, e);
  endtask
  task automatic fchk(input string req, input int a, input logic [31:0] e);
    fpr_ra = 4'(a); #1; chk(req, fpr_rd, e);
  endtask

  task automatic t_reset;
    chk("R1 sr", sr_rd, 32'h7000_00F0);
    chk("R1 fpscr", fpscr_rd, 32'h0004_0001);
    for (int i = 0; i < 16; i++) begin gchk("R1 gpr", i, 0); fchk("R1 fpr", i, 0); end
  endtask

  // reset selects bank 1 (bits 30 and 29 both set)
  task automatic t_int_swap;
    for (int i = 0; i < 16; i++) gw(i, 32'hA000_0000 + i);
    for (int i = 0; i < 16; i++) gchk("R2", i, 32'hA000_0000 + i);
    srw(32'h0000_00F0);
    for (int i = 0; i < 8; i++) gchk("R4 other bank empty", i, 0);
    for (int i = 8; i < 16; i++) gchk("R3 shared", i, 32'hA000_0000 + i);
    for (int i = 0; i < 8; i++) gw(i, 32'hB000_0000 + i);
    srw(32'h6000_00F0);
    for (int i = 0; i < 8; i++) gchk("R4 back to A", i, 32'hA000_0000 + i);
    for (int i = 8; i < 16; i++) gchk("R3 shared", i, 32'hA000_0000 + i);
    srw(32'h1000_00F0);
    for (int i = 0; i < 8; i++) gchk("R4 back to B", i, 32'hB000_0000 + i);
  endtask

  task automatic t_no_swap;
    srw(32'h4000_00F0); gchk("R5 md only", 2, 32'hB000_0002);
    srw(32'h2000_00F0); gchk("R5 rb only", 5, 32'hB000_0005);
    srw(32'h7000_00F0); gchk("R4 sel1", 5, 32'hA000_0005);
    srw(32'h6000_0000); gchk("R5 both kept", 5, 32'hA000_0005);
  endtask

  task automatic t_fp_swap;
    for (int i = 0; i < 16; i++) fw(i, 32'hC000_0000 + i);
    for (int i = 0; i < 16; i++) fchk("R6 write", i, 32'hC000_0000 + i);
    fcw(32'h0024_0001);
    chk("R9 fpscr", fpscr_rd, 32'h0024_0001);
    for (int i = 0; i < 16; i++) fchk("R6 other bank empty", i, 0);
    for (int i = 0; i < 16; i++) fw(i, 32'hD000_0000 + i);
    fcw(32'h0004_0001);
    for (int i = 0; i < 16; i++) fchk("R6 back to C", i, 32'hC000_0000 + i);
    fcw(32'h0000_0000);
    fchk("R6 no toggle", 7, 32'hC000_0007);
    fcw(32'h0020_0000);
    for (int i = 0; i < 16; i++) fchk("R6 back to D", i, 32'hD000_0000 + i);
  endtask

  task automatic t_flags;
    srw(32'h7000_0303); chk("R7 load", sr_rd, 32'h7000_0303);
    @(negedge clk); flag_we = 1; flg = 4'b0000;
    @(negedge clk); flag_we = 0; chk("R7 clear", sr_rd, 32'h7000_0000);
    @(negedge clk); flag_we = 1; flg = 4'b1001;
    @(negedge clk); flag_we = 0; chk("R7 m,t", sr_rd, 32'h7000_0201);
    @(negedge clk); flag_we = 1; flg = 4'b0110; sr_we = 1; sr_wd = 32'h7000_0102;
    @(negedge clk); flag_we = 0; sr_we = 0; chk("R7 sr wins", sr_rd, 32'h7000_0102);
    srw(32'h7000_00F0); chk("R9 sr", sr_rd, 32'h7000_00F0);
  endtask

  task automatic t_same_cycle;
    // now bank A selected; write r3 while switching to B
    @(negedge clk); sr_we = 1; sr_wd = 32'h0000_00F0; gpr_we = 1; gpr_wa = 3; gpr_wd = 32'hE333_0003;
    @(negedge clk); sr_we = 0; gpr_we = 0;
    gchk("R8 new bank gets write", 3, 32'hE333_0003);
    srw(32'h6000_00F0); gchk("R8 old bank untouched", 3, 32'hA000_0003);
    // fp: bank D selected; write f9 while switching to C
    @(negedge clk); fpscr_we = 1; fpscr_wd = 32'h0000_0000; fpr_we = 1; fpr_wa = 9; fpr_wd = 32'hE999_0009;
    @(negedge clk); fpscr_we = 0; fpr_we = 0;
    fchk("R8 fp new bank", 9, 32'hE999_0009);
    fcw(32'h0020_0000); fchk("R8 fp old bank", 9, 32'hD000_0009);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_int_swap();
    t_no_swap();
    t_fp_swap();
    t_flags();
    t_same_cycle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule